// File: doc/BRIEF.md
# Area-Based External Bus Interface

This block sits between an internal requester and an external memory bus that is divided into eight areas. Each request address is decoded to an area, and the matching active-low chip select is driven for the length of a basic read or write cycle. The cycle follows the settings of that area, which are held on static configuration inputs: the data width (8 or 16 bits), a two-state or three-state base cycle, and a programmed wait count. In three-state areas an external wait input can stretch the cycle further.

A mode input picks the size of the address space. In the small mode the space is 1 Mbyte and each area covers 128 kbytes. In the large mode the space is 16 Mbytes and each area covers 2 Mbytes. Narrow areas carry their bytes on the upper data lane. A 16-bit request to a narrow area is split into two byte cycles, and the requester sees one acknowledge at the end of the second. The requester holds its request until the acknowledge pulse and drops or replaces it in that same cycle.

Top module: `ext_area_bus`

## Requirements
- R1: The area index is request address bits [19:17] when `mode_big` is 0 and bits [23:21] when it is 1. Only chip select `cs_n[index]` goes low for that request.
- R2: At most one chip select is low at any time, and the low one does not change within a cycle. All chip selects are high for at least one clock between any two bus cycles, including the two halves of a split request.
- R3: In an area whose `cfg_three` bit is 0, every bus cycle lasts exactly 2 clocks. The programmed waits and `wait_n` have no effect there.
- R4: In an area whose `cfg_three` bit is 1, a bus cycle lasts 3 + W clocks while `wait_n` stays high. W is the area's 2-bit field `cfg_waits[2i+1:2i]`.
- R5: In a three-state area, `wait_n` is sampled at the end of the last programmed wait state (or at the end of the second state when W = 0). Each low sample adds one clock, and a low level at any earlier point has no effect.
- R6: A word request (`req_word` = 1) to an area whose `cfg_bus16` bit is 0 runs two byte cycles. The first is at the even address and carries bits [15:8]. The second is at the even address + 1 and carries bits [7:0].
- R7: Writes are steered onto byte lanes. Narrow areas use `data_out[15:8]` with `wr_hi_n` only. 16-bit areas use both lanes and both strobes for a word. A 16-bit area byte at an even address uses the upper lane and `wr_hi_n`; at an odd address it uses the lower lane and `wr_lo_n`. Byte write data is taken from `req_wdata[7:0]`.
- R8: `rd_n` is low for the whole of a read cycle. A byte read returns its byte in `req_rdata[7:0]`, taken from `data_in[15:8]` for narrow areas and even addresses, and from `data_in[7:0]` for odd addresses in 16-bit areas. A word read returns the even-address byte in bits [15:8].
- R9: Write strobes are high in the first state of a cycle and low in all later states. `data_oe` is high for the whole of a write cycle and low during reads. No write strobe falls during a read.
- R10: `req_ack` is a one-clock pulse in the clock after the last state of the last cycle. All chip selects are high in that clock, and no new request is accepted in it.
- R11: In small mode `bus_addr` bits [23:20] are 0. A word access to a 16-bit area drives `bus_addr[0]` as 0.
- R12: While reset is held, all chip selects and strobes are high, and `req_ack` and `data_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_big | input | 1 | 0: 1-Mbyte space, 1: 16-Mbyte space |
| cfg_bus16 | input | 8 | Per-area 16-bit width enable |
| cfg_three | input | 8 | Per-area three-state cycle enable |
| cfg_waits | input | 16 | Per-area programmed wait count, 2 bits each |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for 16-bit access, 0 for byte |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Request complete pulse |
| req_rdata | output | 16 | Read result, valid with `req_ack` |
| bus_addr | output | 24 | External address |
| cs_n | output | 8 | Active-low chip select per area |
| rd_n | output | 1 | Active-low read strobe |
| wr_hi_n | output | 1 | Active-low upper-lane write strobe |
| wr_lo_n | output | 1 | Active-low lower-lane write strobe |
| data_out | output | 16 | Write data to the bus |
| data_oe | output | 1 | Data bus drive enable |
| data_in | input | 16 | Read data from the bus |
| wait_n | input | 1 | Active-low external wait |

## Verification
A corrupted sequencer state shows up within the same bus cycle as a chip-select window of the wrong length, counted in clocks from the falling edge. A latched area or configuration error shows as the wrong select or the wrong strobe lane in the first or second state. A lost split phase shows as a missing second window or a misplaced acknowledge one clock after the expected end. The bench drives `wait_n` low for a chosen count measured from the start of each window, so an error in where the pin is sampled changes the window length at once.

// File: rtl/ext_area_pkg.sv
package ext_area_pkg;
   localparam int DATA_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_T1,
      ST_T2,
      ST_TW,
      ST_T3,
      ST_GAP
   } bus_state_t;
endpackage

// File: rtl/ext_area_decode.sv
module ext_area_decode #(
   parameter int ADDR_W    = 24,
   parameter int N_AREA    = 8,
   parameter int SMALL_LSB = 17,
   parameter int BIG_LSB   = 21,
   localparam int AREA_W   = $clog2(N_AREA),
   localparam int SMALL_TOP = SMALL_LSB + AREA_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mode_big,
   output logic [AREA_W-1:0] area,
   output logic [ADDR_W-1:0] eff_addr
);
   assign area = mode_big ? addr[BIG_LSB +: AREA_W] : addr[SMALL_LSB +: AREA_W];

   // bits above the small-space window exist only in the large mode
   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < SMALL_TOP) begin : g_keep
         assign eff_addr[b] = addr[b];
      end else begin : g_mask
         assign eff_addr[b] = addr[b] & mode_big;
      end
   end
endmodule

// File: rtl/ext_area_lanes.sv
module ext_area_lanes
   import ext_area_pkg::*;
(
   input  logic              bus16,
   input  logic              word,
   input  logic              phase,
   input  logic              addr0,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] rcur,
   output logic [DATA_W-1:0] dout,
   output logic              hi_en,
   output logic              lo_en,
   output logic [DATA_W-1:0] rnext
);
   always_comb begin
      hi_en = 1'b1;
      lo_en = 1'b0;
      dout  = {wdata[7:0], 8'h00};
      rnext = {8'h00, data_in[15:8]};
      if (bus16) begin
         if (word) begin
            lo_en = 1'b1;
            dout  = wdata;
            rnext = data_in;
         end else if (addr0) begin
            hi_en = 1'b0;
            lo_en = 1'b1;
            dout  = {8'h00, wdata[7:0]};
            rnext = {8'h00, data_in[7:0]};
         end
      end else if (word) begin
         if (!phase) begin
            dout  = {wdata[15:8], 8'h00};
            rnext = {data_in[15:8], rcur[7:0]};
         end else begin
            rnext = {rcur[15:8], data_in[15:8]};
         end
      end
   end
endmodule

// File: rtl/ext_area_seq.sv
module ext_area_seq
   import ext_area_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int N_AREA = 8,
   parameter int WAIT_W = 2,
   localparam int AREA_W = $clog2(N_AREA)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic                     req_word,
   input  logic [ADDR_W-1:0]        eff_addr,
   input  logic [AREA_W-1:0]        area,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [N_AREA-1:0]        cfg_bus16,
   input  logic [N_AREA-1:0]        cfg_three,
   input  logic [N_AREA*WAIT_W-1:0] cfg_waits,
   input  logic                     wait_n,
   output bus_state_t               st,
   output logic [AREA_W-1:0]        a_area,
   output logic                     a_write,
   output logic                     a_word,
   output logic                     a_bus16,
   output logic                     phase,
   output logic [DATA_W-1:0]        a_wdata,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic                     ack,
   output logic                     capture
);
   logic [ADDR_W-1:0] a_addr;
   logic              a_three;
   logic [WAIT_W-1:0] a_waits;
   logic [WAIT_W-1:0] wleft;
   logic              a_split;

   assign a_split  = a_word && !a_bus16;
   assign capture  = (st == ST_T2 && !a_three) || (st == ST_T3);
   assign bus_addr = {a_addr[ADDR_W-1:1], a_word ? phase : a_addr[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         a_area  <= '0;
         a_write <= 1'b0;
         a_word  <= 1'b0;
         a_bus16 <= 1'b0;
         a_three <= 1'b0;
         a_waits <= '0;
         a_addr  <= '0;
         a_wdata <= '0;
         wleft   <= '0;
         phase   <= 1'b0;
         ack     <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (capture) begin
            if (a_split && !phase) begin
               phase <= 1'b1;
               st    <= ST_GAP;
            end else begin
               st  <= ST_IDLE;
               ack <= 1'b1;
            end
         end else begin
            case (st)
               ST_IDLE: if (req_valid && !ack) begin
                  a_area  <= area;
                  a_write <= req_write;
                  a_word  <= req_word;
                  a_addr  <= eff_addr;
                  a_wdata <= req_wdata;
                  a_bus16 <= cfg_bus16[area];
                  a_three <= cfg_three[area];
                  a_waits <= cfg_waits[area*WAIT_W +: WAIT_W];
                  phase   <= 1'b0;
                  st      <= ST_T1;
               end
               ST_T1: st <= ST_T2;
               ST_T2: begin
                  // only three-state areas reach here without capture
                  if (a_waits != '0) begin
                     wleft <= a_waits - WAIT_W'(1);
                     st    <= ST_TW;
                  end else if (!wait_n) begin
                     wleft <= '0;
                     st    <= ST_TW;
                  end else begin
                     st <= ST_T3;
                  end
               end
               ST_TW: begin
                  if (wleft != '0) wleft <= wleft - WAIT_W'(1);
                  else if (wait_n) st <= ST_T3;
               end
               ST_GAP: st <= ST_T1;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ext_area_bus.sv
module ext_area_bus
   import ext_area_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int N_AREA    = 8,
   parameter int WAIT_W    = 2,
   parameter int SMALL_LSB = 17,
   parameter int BIG_LSB   = 21,
   localparam int AREA_W   = $clog2(N_AREA)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_big,
   input  logic [N_AREA-1:0]        cfg_bus16,
   input  logic [N_AREA-1:0]        cfg_three,
   input  logic [N_AREA*WAIT_W-1:0] cfg_waits,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic                     req_word,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ack,
   output logic [DATA_W-1:0]        req_rdata,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [N_AREA-1:0]        cs_n,
   output logic                     rd_n,
   output logic                     wr_hi_n,
   output logic                     wr_lo_n,
   output logic [DATA_W-1:0]        data_out,
   output logic                     data_oe,
   input  logic [DATA_W-1:0]        data_in,
   input  logic                     wait_n
);
   if (N_AREA < 2 || (N_AREA & (N_AREA - 1)) != 0) begin : g_bad_area
      $error("N_AREA must be a power of two of at least 2");
   end
   if (SMALL_LSB >= BIG_LSB || BIG_LSB + AREA_W > ADDR_W) begin : g_bad_span
      $error("area windows do not fit the address width");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("WAIT_W must be at least 1");
   end

   logic [AREA_W-1:0] area, a_area;
   logic [ADDR_W-1:0] eff_addr;
   bus_state_t        st;
   logic              a_write, a_word, a_bus16, phase, capture, active;
   logic              hi_en, lo_en;
   logic [DATA_W-1:0] a_wdata, rnext, rdata_q;

   ext_area_decode #(
      .ADDR_W(ADDR_W), .N_AREA(N_AREA), .SMALL_LSB(SMALL_LSB), .BIG_LSB(BIG_LSB)
   ) u_dec (
      .addr(req_addr), .mode_big(mode_big), .area(area), .eff_addr(eff_addr)
   );

   ext_area_seq #(.ADDR_W(ADDR_W), .N_AREA(N_AREA), .WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .eff_addr(eff_addr), .area(area), .req_wdata(req_wdata),
      .cfg_bus16(cfg_bus16), .cfg_three(cfg_three), .cfg_waits(cfg_waits),
      .wait_n(wait_n), .st(st), .a_area(a_area), .a_write(a_write), .a_word(a_word),
      .a_bus16(a_bus16), .phase(phase), .a_wdata(a_wdata), .bus_addr(bus_addr),
      .ack(req_ack), .capture(capture)
   );

   ext_area_lanes u_lanes (
      .bus16(a_bus16), .word(a_word), .phase(phase), .addr0(bus_addr[0]),
      .wdata(a_wdata), .data_in(data_in), .rcur(rdata_q), .dout(data_out),
      .hi_en(hi_en), .lo_en(lo_en), .rnext(rnext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (capture && !a_write) rdata_q <= rnext;
   end

   assign req_rdata = rdata_q;
   assign active    = (st == ST_T1) || (st == ST_T2) || (st == ST_TW) || (st == ST_T3);

   for (genvar i = 0; i < N_AREA; i++) begin : g_cs
      assign cs_n[i] = !(active && a_area == AREA_W'(i));
   end

   assign rd_n    = !(active && !a_write);
   assign wr_hi_n = !(active && a_write && st != ST_T1 && hi_en);
   assign wr_lo_n = !(active && a_write && st != ST_T1 && lo_en);
   assign data_oe = active && a_write;
endmodule

// File: rtl/ext_area_bus_chk.sv
module ext_area_bus_chk #(
   parameter int ADDR_W    = 24,
   parameter int N_AREA    = 8,
   parameter int WAIT_W    = 2,
   parameter int SMALL_LSB = 17,
   localparam int AREA_W   = $clog2(N_AREA)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     mode_big,
   input logic [N_AREA-1:0]        cfg_three,
   input logic [N_AREA*WAIT_W-1:0] cfg_waits,
   input logic [N_AREA-1:0]        cs_n,
   input logic                     rd_n,
   input logic                     wr_hi_n,
   input logic                     wr_lo_n,
   input logic                     data_oe,
   input logic                     req_ack,
   input logic [ADDR_W-1:0]        bus_addr
);
   logic [7:0]        win_len;
   logic [AREA_W-1:0] low_idx, last_area;

   always_comb begin
      low_idx = '0;
      for (int i = 0; i < N_AREA; i++) if (!cs_n[i]) low_idx = AREA_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_len   <= '0;
         last_area <= '0;
      end else if (&cs_n) begin
         win_len <= '0;
      end else begin
         if (win_len != 8'hFF) win_len <= win_len + 8'd1;
         last_area <= low_idx;
      end
   end

   a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);
   a_r2_select_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&cs_n) && !$past(&cs_n)) |-> (cs_n == $past(cs_n)));
   a_r3_two_state_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(&cs_n) && !cfg_three[last_area]) |-> (win_len == 8'd2));
   a_r4_three_state_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(&cs_n) && cfg_three[last_area]) |->
         (32'(win_len) >= 3 + 32'(cfg_waits[last_area*WAIT_W +: WAIT_W])));
   a_r9_no_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (wr_hi_n && wr_lo_n && !data_oe));
   a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (&cs_n));
   a_r11_small_space: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_big && !(&cs_n)) |-> ((bus_addr >> (SMALL_LSB + AREA_W)) == '0));
endmodule

bind ext_area_bus ext_area_bus_chk #(
   .ADDR_W(ADDR_W), .N_AREA(N_AREA), .WAIT_W(WAIT_W), .SMALL_LSB(SMALL_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_big(mode_big), .cfg_three(cfg_three),
   .cfg_waits(cfg_waits), .cs_n(cs_n), .rd_n(rd_n), .wr_hi_n(wr_hi_n),
   .wr_lo_n(wr_lo_n), .data_oe(data_oe), .req_ack(req_ack), .bus_addr(bus_addr)
);

// File: tb/sim_ext_area_bus.sv
module sim_ext_area_bus;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_big = 1'b0;
   logic [7:0]  cfg_bus16 = 8'h55;
   logic [7:0]  cfg_three = 8'hBC;
   logic [15:0] cfg_waits = 16'h3B40;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ack;
   logic [15:0] req_rdata;
   logic [23:0] bus_addr;
   logic [7:0]  cs_n;
   logic        rd_n, wr_hi_n, wr_lo_n, data_oe;
   logic [15:0] data_out, data_in;
   logic        wait_n = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_area_bus u0 (
      .clk(clk), .rst_n(rst_n), .mode_big(mode_big), .cfg_bus16(cfg_bus16),
      .cfg_three(cfg_three), .cfg_waits(cfg_waits), .req_valid(req_valid),
      .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
      .bus_addr(bus_addr), .cs_n(cs_n), .rd_n(rd_n), .wr_hi_n(wr_hi_n),
      .wr_lo_n(wr_lo_n), .data_out(data_out), .data_oe(data_oe),
      .data_in(data_in), .wait_n(wait_n)
   );

   // external memory model: each lane a fixed function of the address
   assign data_in = {bus_addr[7:0] ^ 8'h5A, bus_addr[7:0] ^ 8'hC3};

   typedef struct {
      int          area;
      logic [23:0] addr;
      bit          wr;
      bit          hi;
      bit          lo;
      logic [7:0]  dhi;
      logic [7:0]  dlo;
      int          len;
   } exp_t;

   exp_t q[$];
   int   checks = 0, errors = 0;
   int   pin_lows = 0, cur_w = 0;
   bit   done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // monitor: measures each chip-select window and drives the wait pin
   int          cnt = 0, m_area = 0;
   logic [23:0] m_addr;
   logic        m_rd1, m_hi1, m_lo1, m_oe, m_hi2, m_lo2;
   logic [15:0] m_dout;
   exp_t        e;
   initial begin
      forever begin
         @(negedge clk);
         if (cs_n != 8'hFF) begin
            cnt++;
            if (cnt == 1) begin
               chk("R2 one select", $countones(~cs_n), 1);
               for (int i = 0; i < 8; i++) if (!cs_n[i]) m_area = i;
               m_addr = bus_addr; m_rd1 = rd_n; m_hi1 = wr_hi_n;
               m_lo1 = wr_lo_n; m_oe = data_oe;
            end
            if (cnt == 2) begin
               m_hi2 = wr_hi_n; m_lo2 = wr_lo_n; m_dout = data_out;
            end
         end else if (cnt > 0) begin
            if (q.size() == 0) begin
               chk("R6 unexpected bus cycle", 1, 0);
            end else begin
               e = q.pop_front();
               chk("R1 area select", m_area, e.area);
               chk("R11 bus address", m_addr, e.addr);
               if (e.len == 2) chk("R3 cycle length", cnt, e.len);
               else chk("R4 R5 cycle length", cnt, e.len);
               chk("R8 read strobe", m_rd1, e.wr);
               chk("R9 drive enable", m_oe, e.wr);
               if (e.wr) begin
                  chk("R9 first state strobes", {m_hi1, m_lo1}, 2'b11);
                  chk("R7 upper strobe", m_hi2, !e.hi);
                  chk("R7 lower strobe", m_lo2, !e.lo);
                  if (e.hi) chk("R7 upper lane", m_dout[15:8], e.dhi);
                  if (e.lo) chk("R7 lower lane", m_dout[7:0], e.dlo);
               end else begin
                  chk("R9 no write strobe in read", {m_hi2, m_lo2}, 2'b11);
               end
            end
            cnt = 0;
         end
         wait_n = !(pin_lows != 0 && cnt != 0 && cnt < 2 + cur_w + pin_lows);
      end
   end

   function automatic void push(input int ar, input logic [23:0] a, input bit wr,
                                input bit hi, input bit lo, input logic [7:0] dh,
                                input logic [7:0] dl, input int len);
      exp_t x;
      x.area = ar; x.addr = a; x.wr = wr; x.hi = hi; x.lo = lo;
      x.dhi = dh; x.dlo = dl; x.len = len;
      q.push_back(x);
   endfunction

   // driver: predicts bus cycles into the scoreboard, then runs the request
   task automatic do_req(input bit wr, input bit word, input logic [23:0] addr,
                         input logic [15:0] wd);
      int          ar, len;
      logic [23:0] eff, ae;
      logic [15:0] exp_rd;
      bit          b16, got;
      ar    = mode_big ? int'(addr[23:21]) : int'(addr[19:17]);
      eff   = mode_big ? addr : {4'h0, addr[19:0]};
      ae    = {eff[23:1], 1'b0};
      b16   = cfg_bus16[ar];
      cur_w = int'(cfg_waits[ar*2 +: 2]);
      len   = cfg_three[ar] ? 3 + cur_w + pin_lows : 2;
      if (b16 && word) begin
         push(ar, ae, wr, wr, wr, wd[15:8], wd[7:0], len);
         exp_rd = {ae[7:0] ^ 8'h5A, ae[7:0] ^ 8'hC3};
      end else if (b16) begin
         push(ar, eff, wr, wr && !eff[0], wr && eff[0], wd[7:0], wd[7:0], len);
         exp_rd = {8'h00, eff[0] ? eff[7:0] ^ 8'hC3 : eff[7:0] ^ 8'h5A};
      end else if (word) begin
         push(ar, ae, wr, wr, 0, wd[15:8], 8'h00, len);
         push(ar, ae | 24'h1, wr, wr, 0, wd[7:0], 8'h00, len);
         exp_rd = {ae[7:0] ^ 8'h5A, (ae[7:0] | 8'h01) ^ 8'h5A};
      end else begin
         push(ar, eff, wr, wr, 0, wd[7:0], 8'h00, len);
         exp_rd = {8'h00, eff[7:0] ^ 8'h5A};
      end
      @(negedge clk);
      req_valid = 1; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
      got = 0;
      for (int t = 0; t < 80 && !got; t++) begin
         @(negedge clk);
         if (req_ack) got = 1;
      end
      chk("R10 acknowledge seen", got, 1);
      if (got) begin
         chk("R10 selects idle at acknowledge", cs_n, 8'hFF);
         if (!wr) chk("R8 read result", req_rdata, exp_rd);
      end
      req_valid = 0;
      @(negedge clk);
      chk("R10 single acknowledge", req_ack, 0);
      chk("R6 all byte cycles seen", q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset selects", cs_n, 8'hFF);
      chk("R12 reset strobes", {rd_n, wr_hi_n, wr_lo_n}, 3'b111);
      chk("R12 reset ack and enable", {req_ack, data_oe}, 2'b00);
      rst_n = 1;
      @(negedge clk);
      chk("R12 idle after reset", cs_n, 8'hFF);

      // small mode, junk in bits [23:20] must not reach the bus (R11)
      for (int a = 0; a < 8; a++) begin
         do_req(1, 1, {4'h9, a[2:0], 17'h00A40} + 24'(a), 16'h1234 + 16'(a));
         do_req(0, 1, {4'h6, a[2:0], 17'h01B22}, 16'h0);
         do_req(1, 0, {4'h3, a[2:0], 17'h00C15}, 16'hBEEF);
         do_req(0, 0, {4'h0, a[2:0], 17'h00C15}, 16'h0);
         do_req(0, 0, {4'hF, a[2:0], 17'h00C16}, 16'h0);
      end

      // wait pin held low for a while: stretches three-state areas only (R5, R3)
      pin_lows = 2;
      do_req(0, 1, {4'h0, 3'd2, 17'h00010}, 16'h0);
      do_req(1, 1, {4'h0, 3'd4, 17'h00020}, 16'hA55A);
      do_req(1, 1, {4'h0, 3'd5, 17'h00030}, 16'h0FF0);
      do_req(0, 0, {4'h0, 3'd0, 17'h00041}, 16'h0);
      do_req(1, 0, {4'h0, 3'd6, 17'h00051}, 16'h00C3);
      pin_lows = 1;
      do_req(0, 0, {4'h0, 3'd7, 17'h00061}, 16'h0);
      do_req(1, 1, {4'h0, 3'd3, 17'h00070}, 16'h7E81);
      pin_lows = 0;

      // large mode: area from [23:21], bits [20:17] not decoded (R1)
      mode_big = 1;
      for (int a = 0; a < 8; a++) begin
         do_req(1, 1, {a[2:0], 4'hA, 17'h00103}, 16'h5500 + 16'(a));
         do_req(0, 1, {a[2:0], 4'h5, 17'h000F1}, 16'h0);
      end
      repeat (4) @(negedge clk);
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end
endmodule